// File: doc/BRIEF.md
# Cascadable Dual-Stage Compare Timer

The block is an interval timer built from a 4-bit up-counter (the low stage) and an 8-bit up-counter (the high stage), each with its own compare value. A two-bit cascade field arranges the stages in one of three ways:
- chained into a single 12-bit counter;
- the low stage acting as a programmable prescaler in front of the high stage;
- the two stages running side by side, with the low stage serving only as a free prescaler for its own pulse output.

Counting is paced by one of five synchronous clock-enable inputs, chosen by a 3-bit selector.

Two 3-bit action masks decide what happens when the high stage reaches its compare value (a match) or steps past 255 (a wrap). Either event can return the counter to zero, invert the waveform output, or raise a one-cycle interrupt, in any combination. With these masks the block produces periodic interrupts, square waves, single pulses and duty cycles. Each compare hit of the low stage also yields a one-cycle pulse on its own output.

A two-state controller governs counting. In state HALT the counters are held at zero. In state COUNT they advance on the selected enable. The transition HALT→COUNT (start) is taken on a clock edge where `run` is 1. The transition COUNT→HALT (stop) is taken on an edge where `run` is 0. Both states otherwise hold.

Top module: `dual_stage_timer`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `cnt_lo`, `cnt_hi`, `pre_pulse`, `wave_out` and `irq` are all 0, and the controller is in HALT.
- R2: A tick occurs on a clock edge in COUNT where `src_en[src_sel]` is 1 for `src_sel` 0 to 4. Codes 5, 6 and 7 never tick, and the counters then hold their values.
- R3: On an edge where `run` is 0 the controller enters HALT. On every edge spent in HALT both counters become 0, while `wave_out` keeps its value. On an edge where `run` is 1 the controller enters COUNT, and counting starts on the following edge.
- R4: With `casc_mode` = 00 (wide), the low stage increments on every tick and wraps from 15 to 0. The high stage increments on each tick where the low stage is 15.
- R5: With `casc_mode` = 01 (prescaled), a tick on which `cnt_lo` equals `cmp_lo` returns the low stage to 0; other ticks increment it. The high stage increments only on those compare ticks.
- R6: With `casc_mode` = 10 or 11 (split), the low stage behaves as in R5, and the high stage increments on every tick.
- R7: `pre_pulse` is 1 for exactly the cycle after a tick on which `cnt_lo` equals `cmp_lo`, in every mode.
- R8: A match is defined per mode.
  - In wide mode it is a tick where `cnt_lo`=`cmp_lo` and `cnt_hi`=`cmp_hi`.
  - In the other modes it is a high-stage advance while `cnt_hi`=`cmp_hi`.
  - A wrap is a high-stage advance while `cnt_hi` is 255; it brings `cnt_hi` to 0.
- R9: Action bit 0 (reset) of `act_on_match` / `act_on_wrap` makes the triggering event set `cnt_hi` to 0 instead of advancing it. In wide mode it also sets `cnt_lo` to 0.
- R10: Action bit 1 (toggle) inverts `wave_out` on the edge of the event. When a match and a wrap both request it on the same edge, `wave_out` inverts once.
- R11: Action bit 2 (interrupt) makes `irq` 1 for exactly the cycle after the event. When both events request it on the same edge, there is a single pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Start (1) or stop (0) request to the controller |
| src_sel | input | 3 | Tick source code; 5 to 7 stop counting |
| src_en | input | 5 | Candidate clock enables |
| casc_mode | input | 2 | 00 wide, 01 prescaled, 10/11 split |
| cmp_lo | input | 4 | Low-stage compare value |
| cmp_hi | input | 8 | High-stage compare value |
| act_on_match | input | 3 | Actions on match: bit0 reset, bit1 toggle, bit2 interrupt |
| act_on_wrap | input | 3 | Actions on wrap, same bit meaning |
| cnt_lo | output | 4 | Low-stage count |
| cnt_hi | output | 8 | High-stage count |
| pre_pulse | output | 1 | One-cycle pulse per low-stage compare tick |
| wave_out | output | 1 | Toggled waveform output |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
A match and a wrap of the high stage fall on the same edge when the high compare value is 255. In split mode this happens on every 256th tick; in wide mode it needs the low stage at both 15 and its compare value. Directed phases set `cmp_hi` to 255 with toggle and interrupt requested by both masks. Random phases reach the same coincidence by chance. The bench model merges the two requests by OR, so the expected result is one inversion of `wave_out` and one single-cycle `irq`. A design that applies the toggle twice, or raises the interrupt for two cycles, disagrees with the model on that cycle.

// File: rtl/dst_pkg.sv
package dst_pkg;

    typedef enum logic [1:0] {
        CASC_WIDE  = 2'b00,
        CASC_PRESC = 2'b01,
        CASC_SPLIT = 2'b10,
        CASC_SPLT2 = 2'b11
    } casc_e;

    typedef enum logic {
        ST_HALT  = 1'b0,
        ST_COUNT = 1'b1
    } run_state_e;

    localparam int ACT_RST = 0;
    localparam int ACT_TOG = 1;
    localparam int ACT_IRQ = 2;
    localparam int ACT_W   = 3;

endpackage

// File: rtl/dst_clk_sel.sv
module dst_clk_sel #(
    parameter int NSRC  = 5,
    parameter int SEL_W = 3
) (
    input  logic [NSRC-1:0]  src_en,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [NSRC-1:0] hit;

    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_src
            assign hit[g] = src_en[g] && (sel == SEL_W'(g));
        end
    endgenerate

    // codes at or above NSRC select nothing and therefore never tick
    assign tick = |hit;
endmodule

// File: rtl/dst_nib_stage.sv
module dst_nib_stage #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    input  logic         wrap_on_cmp,
    input  logic         force_zero,
    input  logic [W-1:0] cmp,
    output logic [W-1:0] cnt,
    output logic         at_cmp,
    output logic         at_top,
    output logic         pulse
);
    assign at_cmp = (cnt == cmp);
    assign at_top = &cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= step && at_cmp;
            if (clear) begin
                cnt <= '0;
            end else if (step) begin
                if (force_zero || (wrap_on_cmp && at_cmp)) cnt <= '0;
                else                                       cnt <= cnt + 1'b1;
            end
        end
    end

    // R7: a prescaler pulse always follows a tick
    assert_pulse_after_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> $past(step));

    // R5: in wrap-on-compare use a compare tick returns the stage to zero
    assert_cmp_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && wrap_on_cmp && at_cmp && !clear) |=> (cnt == '0));
endmodule

// File: rtl/dst_byte_stage.sv
module dst_byte_stage
    import dst_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             wide,
    input  logic             adv,
    input  logic             nib_hit,
    input  logic [W-1:0]     cmp,
    input  logic [ACT_W-1:0] mask_match,
    input  logic [ACT_W-1:0] mask_wrap,
    output logic [W-1:0]     cnt,
    output logic [ACT_W-1:0] req,
    output logic             wave,
    output logic             irq
);
    logic hit, match_ev, wrap_ev;

    always_comb begin
        hit      = (cnt == cmp);
        match_ev = wide ? (nib_hit && hit) : (adv && hit);
        wrap_ev  = adv && (&cnt);
        req      = ({ACT_W{match_ev}} & mask_match) | ({ACT_W{wrap_ev}} & mask_wrap);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            wave <= 1'b0;
            irq  <= 1'b0;
        end else begin
            wave <= wave ^ req[ACT_TOG];
            irq  <= req[ACT_IRQ];
            if (clear)             cnt <= '0;
            else if (req[ACT_RST]) cnt <= '0;
            else if (adv)          cnt <= cnt + 1'b1;
        end
    end

    // R8: a wrap always brings the stage to zero
    assert_wrap_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && (&cnt) && !clear) |=> (cnt == '0));

    // R10: the waveform only moves on a compare or wrap event
    assert_wave_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wave != $past(wave)) |-> $past(match_ev || wrap_ev));

    // R11: an interrupt follows a counting step
    assert_irq_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(adv || nib_hit));
endmodule

// File: rtl/dual_stage_timer.sv
module dual_stage_timer
    import dst_pkg::*;
#(
    parameter int LO_W  = 4,
    parameter int HI_W  = 8,
    parameter int NSRC  = 5,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] src_sel,
    input  logic [NSRC-1:0]  src_en,
    input  logic [1:0]       casc_mode,
    input  logic [LO_W-1:0]  cmp_lo,
    input  logic [HI_W-1:0]  cmp_hi,
    input  logic [ACT_W-1:0] act_on_match,
    input  logic [ACT_W-1:0] act_on_wrap,
    output logic [LO_W-1:0]  cnt_lo,
    output logic [HI_W-1:0]  cnt_hi,
    output logic             pre_pulse,
    output logic             wave_out,
    output logic             irq
);
    run_state_e state, state_nx;
    casc_e      mode;
    logic       tick, step, halted;
    logic       lo_at_cmp, lo_at_top, nib_hit, adv_hi, wide;
    logic [ACT_W-1:0] req;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HALT;
        else        state <= state_nx;
    end

    // transitions: start and stop
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HALT:  if (run)  state_nx = ST_COUNT;
            ST_COUNT: if (!run) state_nx = ST_HALT;
            default:            state_nx = ST_HALT;
        endcase
    end

    // per-state outputs and cascade steering
    always_comb begin
        mode    = casc_e'(casc_mode);
        halted  = (state == ST_HALT);
        step    = (state == ST_COUNT) && tick;
        wide    = (mode == CASC_WIDE);
        nib_hit = step && lo_at_cmp;
        unique case (mode)
            CASC_WIDE:  adv_hi = step && lo_at_top;
            CASC_PRESC: adv_hi = nib_hit;
            default:    adv_hi = step;
        endcase
    end

    dst_clk_sel #(.NSRC(NSRC), .SEL_W(SEL_W)) u_sel (
        .src_en (src_en),
        .sel    (src_sel),
        .tick   (tick)
    );

    dst_nib_stage #(.W(LO_W)) u_lo (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (halted),
        .step        (step),
        .wrap_on_cmp (!wide),
        .force_zero  (wide && req[ACT_RST]),
        .cmp         (cmp_lo),
        .cnt         (cnt_lo),
        .at_cmp      (lo_at_cmp),
        .at_top      (lo_at_top),
        .pulse       (pre_pulse)
    );

    dst_byte_stage #(.W(HI_W)) u_hi (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (halted),
        .wide       (wide),
        .adv        (adv_hi),
        .nib_hit    (nib_hit),
        .cmp        (cmp_hi),
        .mask_match (act_on_match),
        .mask_wrap  (act_on_wrap),
        .cnt        (cnt_hi),
        .req        (req),
        .wave       (wave_out),
        .irq        (irq)
    );

    // R3: two edges with run low leave both counters at zero
    assert_halt_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!run) && $past(!run, 2)) |-> (cnt_lo == '0 && cnt_hi == '0));

    // R2: without a tick while counting, the counters hold
    assert_no_tick_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && !tick) |=> ($stable(cnt_lo) && $stable(cnt_hi)));

    // R4: in wide mode the high stage moves only on a low-stage wrap
    assert_wide_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && wide && !lo_at_top && req == '0) |=> $stable(cnt_hi));
endmodule

// File: tb/sim_dual_stage_timer.sv
module sim_dual_stage_timer;
    localparam time PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic [2:0] src_sel = '0;
    logic [4:0] src_en = '0;
    logic [1:0] casc_mode = '0;
    logic [3:0] cmp_lo = '0;
    logic [7:0] cmp_hi = '0;
    logic [2:0] act_on_match = '0;
    logic [2:0] act_on_wrap = '0;
    logic [3:0] cnt_lo;
    logic [7:0] cnt_hi;
    logic       pre_pulse, wave_out, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference state
    logic [3:0] m_lo = '0;
    logic [7:0] m_hi = '0;
    logic       m_pp = 1'b0, m_wv = 1'b0, m_irq = 1'b0, m_cnt = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    dual_stage_timer u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .src_sel(src_sel), .src_en(src_en),
        .casc_mode(casc_mode), .cmp_lo(cmp_lo), .cmp_hi(cmp_hi),
        .act_on_match(act_on_match), .act_on_wrap(act_on_wrap),
        .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .pre_pulse(pre_pulse),
        .wave_out(wave_out), .irq(irq)
    );

    function automatic logic sel_tick(input logic [2:0] s, input logic [4:0] e);
        return (s < 3'd5) ? e[s] : 1'b0;
    endfunction

    // one edge of the reference model, from the requirements
    task automatic model_step();
        logic tk, stp, wide, nh, adv, mt, wr;
        logic [2:0] rq;
        tk = sel_tick(src_sel, src_en);
        stp = m_cnt && tk;
        if (!m_cnt) begin
            m_lo = '0; m_hi = '0; m_pp = 1'b0; m_irq = 1'b0;
        end else begin
            wide = (casc_mode == 2'b00);
            nh = stp && (m_lo == cmp_lo);
            if (wide)                    adv = stp && (m_lo == 4'hF);
            else if (casc_mode == 2'b01) adv = nh;
            else                         adv = stp;
            mt = wide ? (nh && m_hi == cmp_hi) : (adv && m_hi == cmp_hi);
            wr = adv && (m_hi == 8'hFF);
            rq = ({3{mt}} & act_on_match) | ({3{wr}} & act_on_wrap);
            if (stp) begin
                if ((wide && rq[0]) || (!wide && m_lo == cmp_lo)) m_lo = '0;
                else m_lo = m_lo + 4'd1;
            end
            if (rq[0])    m_hi = '0;
            else if (adv) m_hi = m_hi + 8'd1;
            m_pp = nh;
            m_wv = m_wv ^ rq[1];
            m_irq = rq[2];
        end
        m_cnt = run;
    endtask

    task automatic check(input string tag);
        logic [14:0] act, exp;
        act = {cnt_lo, cnt_hi, pre_pulse, wave_out, irq};
        exp = {m_lo, m_hi, m_pp, m_wv, m_irq};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual lo=%0d hi=%0d pp=%b wv=%b irq=%b expected lo=%0d hi=%0d pp=%b wv=%b irq=%b",
                     tag, act[14:11], act[10:3], act[2], act[1], act[0],
                     exp[14:11], exp[10:3], exp[2], exp[1], exp[0]);
        end
    endtask

    // inputs are set at the falling edge; one call advances one edge
    task automatic cyc(input string tag);
        @(posedge clk);
        model_step();
        #1;
        check(tag);
        @(negedge clk);
    endtask

    task automatic cfg(input logic [1:0] md, input logic [2:0] s, input logic [4:0] e,
                       input logic [3:0] cl, input logic [7:0] ch,
                       input logic [2:0] am, input logic [2:0] aw);
        casc_mode = md; src_sel = s; src_en = e; cmp_lo = cl; cmp_hi = ch;
        act_on_match = am; act_on_wrap = aw;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual run still going expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        @(negedge clk);
        #1;
        check("R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        cyc("R1 after reset");

        // R4 wide mode, free running, no actions
        cfg(2'b00, 3'd0, 5'b00001, 4'd3, 8'd200, 3'b000, 3'b000);
        run = 1'b1;
        for (int i = 0; i < 60; i++) cyc("R4 wide carry");
        // R7 pulses seen above; R9 wide reset on match: period 2*16+5+1
        cfg(2'b00, 3'd0, 5'b00001, 4'd5, 8'd2, 3'b111, 3'b000);
        for (int i = 0; i < 120; i++) cyc("R9 wide reset");

        // R2 unused codes stop counting
        for (int c = 5; c < 8; c++) begin
            src_sel = 3'(c);
            src_en = 5'b11111;
            for (int i = 0; i < 10; i++) cyc("R2 stop code");
        end
        // R2 each live source, others toggling
        for (int c = 0; c < 5; c++) begin
            src_sel = 3'(c);
            for (int i = 0; i < 12; i++) begin
                src_en = 5'($urandom);
                cyc("R2 source pick");
            end
        end

        // R5 prescaled
        cfg(2'b01, 3'd1, 5'b00010, 4'd2, 8'd4, 3'b011, 3'b000);
        for (int i = 0; i < 80; i++) cyc("R5 prescale");
        // R6 split, both mode codes
        cfg(2'b10, 3'd1, 5'b00010, 4'd7, 8'd9, 3'b101, 3'b000);
        for (int i = 0; i < 40; i++) cyc("R6 split");
        casc_mode = 2'b11;
        for (int i = 0; i < 40; i++) cyc("R6 split alt");

        // R8 R10 R11 coincidence of match and wrap in split mode
        cfg(2'b10, 3'd2, 5'b00100, 4'd1, 8'd255, 3'b110, 3'b110);
        for (int i = 0; i < 600; i++) cyc("R10 R11 coincide");
        // R8 wrap alone, reset only on wrap
        cfg(2'b10, 3'd2, 5'b00100, 4'd1, 8'd100, 3'b000, 3'b111);
        for (int i = 0; i < 300; i++) cyc("R8 wrap");

        // R3 halt clears, wave holds, restart
        run = 1'b0;
        for (int i = 0; i < 6; i++) cyc("R3 halt");
        run = 1'b1;
        for (int i = 0; i < 6; i++) cyc("R3 restart");

        // random phases
        for (int p = 0; p < 250; p++) begin
            cfg(2'($urandom), 3'($urandom_range(0, 7)), 5'($urandom),
                4'($urandom), ($urandom_range(0, 3) == 0) ? 8'd255 : 8'($urandom_range(0, 12)),
                3'($urandom), 3'($urandom));
            for (int i = 0; i < 40; i++) begin
                if ($urandom_range(0, 3) == 0) src_en = 5'($urandom);
                run = ($urandom_range(0, 19) != 0);
                cyc("R8 random mix");
            end
        end
        finish_run();
    end
endmodule